// File: doc/BRIEF.md
# Audio Clock Settings and Power-On Hold Controller

This block decides, cycle by cycle, how a multi-output audio clock generator running from a 27 MHz master clock should be configured. It owns no oscillator or PLL. It produces a sampling-rate code for the two sampling-rate-locked outputs, a halving select for the 44.1 kHz-family output that can be switched, and one enable per output. The six outputs are numbered as follows. Output 0 is the fixed 33.8688 MHz clock. Output 1 is 256 fS and output 2 is 384 fS. Output 3 is the switchable 44.1 kHz-family clock. Outputs 4 and 5 carry the master clock through.

The settings come from one of two sources, chosen by a strap input. In pin mode, two group pins and a rate pin set the rate, and every output stays enabled. In serial mode, a 16-bit word is shifted in and then committed with a strobe. The word sets the group, the rate and the six enables. After the supply-good input rises, an internal counter holds every setting at its default for a fixed number of master clocks. A done flag reports the end of that hold.

Each enable changes only while the level of its own output clock is low. A disabled output is therefore held low and is never cut short. The gated level of each output is driven back out.

Top module: `aclk_cfg_top`

## Requirements
- R1: `por_done_o` is 0 while `supply_ok_i` is low. It rises at the POR_CYCLES-th rising clock edge after `supply_ok_i` goes high, and then stays high.
- R2: While `por_done_o` is 0, the outputs hold their defaults: `fs_sel_o` = 3'b000 (48 kHz, standard), `half_o` = 0 and `en_o` all ones. Pins and serial words are ignored during this time.
- R3: `fs_sel_o` is {double, group[1:0]}. The group code is 00 for 48 kHz, 01 for 44.1 kHz and 10 for 32 kHz. Double = 1 selects 64, 88.2 or 96 kHz. In pin mode (`serial_mode_i` = 0) the group comes from `grp_pin_i` and double comes from `dbl_pin_i`.
- R4: A group code of 11 is reserved. It never appears on `fs_sel_o`, and when it is supplied the previous group is kept.
- R5: `half_o` follows `half_sel_i` in both modes. When `half_o` is 1, output 3 runs at 384 fS of 44.1 kHz; when it is 0, output 3 runs at 768 fS.
- R6: A change on the pins shows on `fs_sel_o` and `half_o` exactly two rising edges later. It does not show after one edge.
- R7: In serial mode, bits are shifted in MSB first, one per rising edge of `ser_clk_i`, and a rising edge of `ser_lat_i` commits the word. The word layout is: [15:10] = 011100, [9:4] = enables for outputs 5..0, [3] = 0, [2] = double, [1:0] = group. The new rate code appears two edges after the strobe is sampled, and the enables follow one edge later.
- R8: A word whose bits [15:10] are not 011100, or whose bit 3 is 1, is discarded as a whole.
- R9: A committed word carrying group 11 still applies its double bit and its enables, but keeps the previous group.
- R10: `en_o[k]` changes only on an edge where `clk_lvl_i[k]` was low. `gated_o` = `clk_lvl_i` AND `en_o`, so a disabled output reads 0.
- R11: When `supply_ok_i` drops, the defaults are restored at once and the hold count starts again from zero.
- R12: In pin mode, serial words are ignored and every enable target is 1. In serial mode, the group and rate pins are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| supply_ok_i | input | 1 | Raw supply-good indication; low clears the block asynchronously |
| serial_mode_i | input | 1 | 0 = pin mode, 1 = serial mode |
| grp_pin_i | input | 2 | Group select pins for pin mode |
| dbl_pin_i | input | 1 | Double-rate pin for pin mode |
| half_sel_i | input | 1 | Halving select for output 3 |
| ser_clk_i | input | 1 | Serial shift clock, sampled by clk_i |
| ser_dat_i | input | 1 | Serial data, MSB first |
| ser_lat_i | input | 1 | Serial commit strobe, acts on its rising edge |
| clk_lvl_i | input | 6 | Present level of each generated output clock |
| fs_sel_o | output | 3 | {double, group} sampling-rate code |
| half_o | output | 1 | Output 3 runs at half frequency |
| en_o | output | 6 | Per-output enable |
| gated_o | output | 6 | Output clock levels after the enable gate |
| por_done_o | output | 1 | Power-on hold finished |

## Verification
The bench builds the block with POR_CYCLES = 32. At that value the exact cycle of the done edge can be checked after the first release and again after a supply drop, and this costs little time. The design timing does not depend on the count, so what holds for 32 holds for 1024. With the small count there is cycle budget left for a full sweep of every group, rate and halving pin combination in pin mode. That sweep probes the one-edge and two-edge points. There is also room for 64 serial words that step through every enable pattern and every group code, with the reserved code included.

// File: rtl/aclk_cfg_pkg.sv
package aclk_cfg_pkg;
   localparam int NUM_OUT = 6;
   localparam int FRAME_W = 16;
   localparam logic [5:0] FRAME_TAG = 6'b011100;

   typedef enum logic [1:0] {
      GRP_48  = 2'b00,
      GRP_44  = 2'b01,
      GRP_32  = 2'b10,
      GRP_RSV = 2'b11
   } grp_e;

   typedef struct packed {
      grp_e               grp;
      logic               dbl;
      logic [NUM_OUT-1:0] en;
   } cfg_t;

   localparam cfg_t CFG_DEFAULT = '{grp: GRP_48, dbl: 1'b0, en: {NUM_OUT{1'b1}}};
endpackage

// File: rtl/aclk_por.sv
module aclk_por #(
   parameter int CYCLES = 1024
) (
   input  logic clk_i,
   input  logic supply_ok_i,
   output logic done_o
);
   localparam int CW = $clog2(CYCLES + 1);

   if (CYCLES < 2) begin : g_bad_cycles
      $error("aclk_por: CYCLES must be at least 2");
   end

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk_i or negedge supply_ok_i) begin
      if (!supply_ok_i) begin
         cnt_q  <= '0;
         done_o <= 1'b0;
      end else if (!done_o) begin
         if (cnt_q == CW'(CYCLES - 1)) done_o <= 1'b1;
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/aclk_ser_rx.sv
module aclk_ser_rx
   import aclk_cfg_pkg::*;
(
   input  logic               clk_i,
   input  logic               supply_ok_i,
   input  logic               ser_clk_i,
   input  logic               ser_dat_i,
   input  logic               ser_lat_i,
   output logic [FRAME_W-1:0] frame_o,
   output logic               commit_o
);
   logic sck_q, sck_qq, dat_q, lat_q, lat_qq;
   logic [FRAME_W-1:0] shreg_q;

   always_ff @(posedge clk_i or negedge supply_ok_i) begin
      if (!supply_ok_i) begin
         sck_q   <= 1'b0;
         sck_qq  <= 1'b0;
         dat_q   <= 1'b0;
         lat_q   <= 1'b0;
         lat_qq  <= 1'b0;
         shreg_q <= '0;
      end else begin
         sck_q  <= ser_clk_i;
         sck_qq <= sck_q;
         dat_q  <= ser_dat_i;
         lat_q  <= ser_lat_i;
         lat_qq <= lat_q;
         if (sck_q && !sck_qq) shreg_q <= {shreg_q[FRAME_W-2:0], dat_q};
      end
   end

   assign frame_o  = shreg_q;
   assign commit_o = lat_q & ~lat_qq;
endmodule

// File: rtl/aclk_cfg_sel.sv
module aclk_cfg_sel
   import aclk_cfg_pkg::*;
(
   input  logic               clk_i,
   input  logic               supply_ok_i,
   input  logic               por_done_i,
   input  logic               serial_mode_i,
   input  logic [1:0]         grp_pin_i,
   input  logic               dbl_pin_i,
   input  logic               half_sel_i,
   input  logic [FRAME_W-1:0] frame_i,
   input  logic               commit_i,
   output cfg_t               cfg_o,
   output logic               half_o
);
   logic       mode_q, dbl_q, half_in_q;
   grp_e       grp_q;
   cfg_t       cfg_q;
   logic       half_q;
   logic       frame_ok;
   grp_e       frame_grp;

   assign frame_grp = grp_e'(frame_i[1:0]);
   assign frame_ok  = (frame_i[FRAME_W-1 -: 6] == FRAME_TAG) && !frame_i[3];

   always_ff @(posedge clk_i or negedge supply_ok_i) begin
      if (!supply_ok_i) begin
         mode_q    <= 1'b0;
         grp_q     <= GRP_48;
         dbl_q     <= 1'b0;
         half_in_q <= 1'b0;
         cfg_q     <= CFG_DEFAULT;
         half_q    <= 1'b0;
      end else begin
         mode_q    <= serial_mode_i;
         grp_q     <= grp_e'(grp_pin_i);
         dbl_q     <= dbl_pin_i;
         half_in_q <= half_sel_i;
         if (por_done_i) begin
            half_q <= half_in_q;
            if (!mode_q) begin
               if (grp_q != GRP_RSV) cfg_q.grp <= grp_q;
               cfg_q.dbl <= dbl_q;
               cfg_q.en  <= {NUM_OUT{1'b1}};
            end else if (commit_i && frame_ok) begin
               if (frame_grp != GRP_RSV) cfg_q.grp <= frame_grp;
               cfg_q.dbl <= frame_i[2];
               cfg_q.en  <= frame_i[4 +: NUM_OUT];
            end
         end
      end
   end

   assign cfg_o  = cfg_q;
   assign half_o = half_q;
endmodule

// File: rtl/aclk_out_gate.sv
module aclk_out_gate #(
   parameter int N = 6
) (
   input  logic         clk_i,
   input  logic         supply_ok_i,
   input  logic [N-1:0] lvl_i,
   input  logic [N-1:0] tgt_i,
   output logic [N-1:0] en_o,
   output logic [N-1:0] gated_o
);
   for (genvar k = 0; k < N; k++) begin : g_out
      always_ff @(posedge clk_i or negedge supply_ok_i) begin
         if (!supply_ok_i)   en_o[k] <= 1'b1;
         else if (!lvl_i[k]) en_o[k] <= tgt_i[k];
      end
      assign gated_o[k] = lvl_i[k] & en_o[k];
   end
endmodule

// File: rtl/aclk_cfg_top.sv
module aclk_cfg_top
   import aclk_cfg_pkg::*;
#(
   parameter int POR_CYCLES = 1024
) (
   input  logic               clk_i,
   input  logic               supply_ok_i,
   input  logic               serial_mode_i,
   input  logic [1:0]         grp_pin_i,
   input  logic               dbl_pin_i,
   input  logic               half_sel_i,
   input  logic               ser_clk_i,
   input  logic               ser_dat_i,
   input  logic               ser_lat_i,
   input  logic [NUM_OUT-1:0] clk_lvl_i,
   output logic [2:0]         fs_sel_o,
   output logic               half_o,
   output logic [NUM_OUT-1:0] en_o,
   output logic [NUM_OUT-1:0] gated_o,
   output logic               por_done_o
);
   logic [FRAME_W-1:0] frame_w;
   logic               commit_w;
   cfg_t               cfg_w;

   aclk_por #(.CYCLES(POR_CYCLES)) por_i (
      .clk_i(clk_i), .supply_ok_i(supply_ok_i), .done_o(por_done_o));

   aclk_ser_rx rx_i (
      .clk_i(clk_i), .supply_ok_i(supply_ok_i), .ser_clk_i(ser_clk_i),
      .ser_dat_i(ser_dat_i), .ser_lat_i(ser_lat_i),
      .frame_o(frame_w), .commit_o(commit_w));

   aclk_cfg_sel sel_i (
      .clk_i(clk_i), .supply_ok_i(supply_ok_i), .por_done_i(por_done_o),
      .serial_mode_i(serial_mode_i), .grp_pin_i(grp_pin_i),
      .dbl_pin_i(dbl_pin_i), .half_sel_i(half_sel_i),
      .frame_i(frame_w), .commit_i(commit_w),
      .cfg_o(cfg_w), .half_o(half_o));

   aclk_out_gate #(.N(NUM_OUT)) gate_i (
      .clk_i(clk_i), .supply_ok_i(supply_ok_i), .lvl_i(clk_lvl_i),
      .tgt_i(cfg_w.en), .en_o(en_o), .gated_o(gated_o));

   assign fs_sel_o = {cfg_w.dbl, cfg_w.grp};
endmodule

// File: rtl/aclk_cfg_chk.sv
module aclk_cfg_chk #(
   parameter int POR_CYCLES = 1024,
   parameter int N          = 6
) (
   input logic         clk_i,
   input logic         supply_ok_i,
   input logic [N-1:0] clk_lvl_i,
   input logic [2:0]   fs_sel_o,
   input logic         half_o,
   input logic [N-1:0] en_o,
   input logic         por_done_o
);
   localparam int CW = $clog2(POR_CYCLES + 1);
   logic [CW-1:0] seen_q;

   always_ff @(posedge clk_i or negedge supply_ok_i) begin
      if (!supply_ok_i)                      seen_q <= '0;
      else if (seen_q != CW'(POR_CYCLES))    seen_q <= seen_q + 1'b1;
   end

   p_por_len_r1: assert property (@(posedge clk_i) disable iff (!supply_ok_i)
      por_done_o == (seen_q == CW'(POR_CYCLES)));

   p_done_sticky_r1: assert property (@(posedge clk_i) disable iff (!supply_ok_i)
      por_done_o |=> por_done_o);

   p_hold_defaults_r2: assert property (@(posedge clk_i) disable iff (!supply_ok_i)
      !por_done_o |-> (fs_sel_o == 3'b000 && !half_o && (&en_o)));

   p_no_reserved_r4: assert property (@(posedge clk_i) disable iff (!supply_ok_i)
      fs_sel_o[1:0] != 2'b11);

   for (genvar k = 0; k < N; k++) begin : g_en
      p_en_low_only_r10: assert property (@(posedge clk_i) disable iff (!supply_ok_i)
         (en_o[k] != $past(en_o[k])) |-> !$past(clk_lvl_i[k]));
   end
endmodule

bind aclk_cfg_top aclk_cfg_chk #(.POR_CYCLES(POR_CYCLES), .N(aclk_cfg_pkg::NUM_OUT)) chk_i (
   .clk_i(clk_i), .supply_ok_i(supply_ok_i), .clk_lvl_i(clk_lvl_i),
   .fs_sel_o(fs_sel_o), .half_o(half_o), .en_o(en_o), .por_done_o(por_done_o));

// File: tb/aclk_cfg_top_tb_top.sv
module aclk_cfg_top_tb_top;
   localparam int POR = 32;

   logic       clk = 1'b0;
   logic       supply_ok = 1'b0, serial_mode = 1'b0;
   logic [1:0] grp_pin = 2'b00;
   logic       dbl_pin = 1'b0, half_sel = 1'b0;
   logic       ser_clk = 1'b0, ser_dat = 1'b0, ser_lat = 1'b0;
   logic [5:0] clk_lvl = 6'h00;
   logic [2:0] fs_sel;
   logic       half;
   logic [5:0] en, gated;
   logic       done;

   int errors = 0;
   int checks = 0;

   always #10 clk = ~clk;

   aclk_cfg_top #(.POR_CYCLES(POR)) dut_i (
      .clk_i(clk), .supply_ok_i(supply_ok), .serial_mode_i(serial_mode),
      .grp_pin_i(grp_pin), .dbl_pin_i(dbl_pin), .half_sel_i(half_sel),
      .ser_clk_i(ser_clk), .ser_dat_i(ser_dat), .ser_lat_i(ser_lat),
      .clk_lvl_i(clk_lvl), .fs_sel_o(fs_sel), .half_o(half),
      .en_o(en), .gated_o(gated), .por_done_o(done));

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic send(input logic [15:0] w);
      for (int i = 15; i >= 0; i--) begin
         ser_dat = w[i]; ser_clk = 1'b0; step(2);
         ser_clk = 1'b1; step(2);
      end
      ser_clk = 1'b0; step(2);
      ser_lat = 1'b1; step(2);
      ser_lat = 1'b0; step(4);
   endtask

   function automatic logic [15:0] word(input logic [5:0] e, input logic d, input logic [1:0] g);
      return {6'b011100, e, 1'b0, d, g};
   endfunction

   initial begin
      logic [1:0] cur_g;
      logic       cur_d;
      logic [2:0] prev_fs;
      step(3);
      chk("R2 reset done", done, 0);
      chk("R2 reset fs", fs_sel, 3'b000);
      chk("R2 reset en", en, 6'h3F);
      grp_pin = 2'b10; dbl_pin = 1'b1; half_sel = 1'b1;
      supply_ok = 1'b1;
      step(POR - 1);
      chk("R1 not yet done", done, 0);
      chk("R2 pins ignored fs", fs_sel, 3'b000);
      chk("R2 pins ignored half", half, 0);
      step(1);
      chk("R1 done", done, 1);
      step(2);
      chk("R3 first apply", fs_sel, 3'b110);
      chk("R5 first apply", half, 1);
      cur_g = 2'b10; cur_d = 1'b1;
      // pin sweep: R3 R4 R5 R6
      for (int g = 0; g < 4; g++) begin
         for (int r = 0; r < 2; r++) begin
            for (int c = 0; c < 2; c++) begin
               prev_fs = {cur_d, cur_g};
               grp_pin = 2'(g); dbl_pin = 1'(r); half_sel = 1'(~c[0]);
               step(1);
               chk("R6 one edge holds", fs_sel, prev_fs);
               step(1);
               if (g != 3) cur_g = 2'(g);
               cur_d = 1'(r);
               chk(g == 3 ? "R4 reserved keeps" : "R3 decode", fs_sel, {cur_d, cur_g});
               chk("R5 half", half, 1'(~c[0]));
               chk("R12 pin mode en", en, 6'h3F);
            end
         end
      end
      // R12: serial word ignored in pin mode
      send(word(6'h00, ~cur_d, 2'b01));
      chk("R12 serial ignored fs", fs_sel, {cur_d, cur_g});
      chk("R12 serial ignored en", en, 6'h3F);
      serial_mode = 1'b1; step(2);
      // R7 R9 sweep
      for (int e = 0; e < 64; e++) begin
         logic [5:0] ev;
         logic       dv;
         ev = 6'(e) ^ 6'h15;
         dv = e[2] ^ e[5];
         send(word(ev, dv, 2'(e)));
         if (e[1:0] != 2'b11) cur_g = 2'(e);
         cur_d = dv;
         chk(e[1:0] == 2'b11 ? "R9 reserved group" : "R7 serial fs", fs_sel, {cur_d, cur_g});
         chk("R7 serial en", en, ev);
      end
      // R12: pins ignored in serial mode
      grp_pin = ~cur_g; dbl_pin = ~cur_d; step(4);
      chk("R12 pins ignored", fs_sel, {cur_d, cur_g});
      // R8: bad tag and reserved bit
      prev_fs = fs_sel;
      send({6'b011101, 6'h2A, 1'b0, ~cur_d, 2'b00});
      chk("R8 bad tag fs", fs_sel, prev_fs);
      send({6'b011100, 6'h2A, 1'b1, ~cur_d, 2'b00});
      chk("R8 bit3 set fs", fs_sel, prev_fs);
      chk("R8 en kept", en, 6'h3F ^ 6'h15 ^ 6'h3F ^ 6'h15 ^ (6'd63 ^ 6'h15));
      // R10 enable gating
      send(word(6'h3F, cur_d, cur_g));
      clk_lvl = 6'h3F;
      send(word(6'h00, cur_d, cur_g));
      chk("R10 held while high", en, 6'h3F);
      chk("R10 gated passes", gated, 6'h3F);
      clk_lvl = 6'h00; step(1);
      chk("R10 switched when low", en, 6'h00);
      clk_lvl = 6'h3F; step(1);
      chk("R10 disabled held low", gated, 6'h00);
      clk_lvl = 6'b000111;
      send(word(6'h3F, cur_d, cur_g));
      chk("R10 per-output gating", en, 6'b111000);
      chk("R10 gated mix", gated, 6'h00);
      // R11 supply drop
      clk_lvl = 6'h00; half_sel = 1'b1;
      supply_ok = 1'b0; step(1);
      chk("R11 done cleared", done, 0);
      chk("R11 fs default", fs_sel, 3'b000);
      chk("R11 en default", en, 6'h3F);
      chk("R11 half default", half, 0);
      supply_ok = 1'b1;
      step(POR - 1);
      chk("R11 recount not done", done, 0);
      step(1);
      chk("R11 recount done", done, 1);
      step(2);
      chk("R11 serial keeps default", fs_sel, 3'b000);
      chk("R5 half after recount", half, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule